// File: doc/BRIEF.md
# Sampled Quadrature Position Decoder

This block turns the two digitised phase signals of one incremental encoder channel into a signed position count. Both phases pass through a two-stage synchroniser. A sample strobe, whose period is set by a small programmable divider of the system clock, then samples them. Each sampled pair is compared with the previous one. Each legal single-phase transition moves the count by one, which gives times-4 resolution. No transition leaves the count alone.

A sample period in which both phases changed cannot be resolved into a direction. The block then keeps the count unchanged and raises a sticky error flag. The flag holds until a clear pulse is given or reset occurs.

Tracking is controlled by a two-state machine. **SEED** is entered on reset. On the first clock after reset it copies the synchronised inputs into the previous-sample register, and it then always moves to **TRACK**. **TRACK** stays in TRACK. On every sample strobe it classifies the step into one of four moves:
- **HOLD**: no change.
- **UP**: forward.
- **DOWN**: reverse.
- **DOUBLE**: both phases changed.

Top module: `qdec_top`

## Requirements
- R1: While reset is asserted (active low), `position` reads 0 and `count_err` reads 0.
- R2: With the pair written as {B,A}, the order 00→01→11→10→00 is forward. Each forward step seen between two consecutive samples adds exactly one to `position`.
- R3: Each reverse step (the opposite order) subtracts exactly one from `position`.
- R4: When the sampled pair is unchanged between samples, `position` and `count_err` do not change.
- R5: When both phases differ between two consecutive samples, `position` keeps its value and `count_err` becomes 1 after that sample.
- R6: `count_err` stays 1 until `err_clr` is high on a clock edge with no new double change. A double change on the same edge as `err_clr` leaves the flag at 1.
- R7: With divider setting n (0 to 3), the inputs are sampled once every 2^n clocks. Setting 0 samples on every clock.
- R8: A new `div_sel` value is adopted only at the next sample strobe. The period already in progress finishes with the old setting.
- R9: `position` is a two's-complement counter of CNT_W bits (default 32) that wraps on overflow and underflow.
- R10: The first clock after reset takes the current synchronised inputs as the baseline, so a non-zero input level at reset release produces no count.
- R11: With setting 0, an input change applied before clock edge k shows on `position` just after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Phase A from the line receiver |
| enc_b | input | 1 | Phase B from the line receiver |
| div_sel | input | SEL_W | Sampling divider setting n, period 2^n clocks |
| err_clr | input | 1 | Clears the sticky count error |
| position | output | CNT_W | Signed position count |
| count_err | output | 1 | Sticky flag: both phases changed within one sample period |

## Verification
The bench goes after these corner cases:
- **Non-zero phase level at reset release.** A decoder that seeds its baseline wrongly would count a phantom step.
- **Double change exactly on the edge where the clear is high.** Giving the clear priority would lose the error.
- **Divider change in the middle of a period.** Adopting it at once would shift every later sample point against the reference model.
- **Stepping faster than the sample rate allows.** This shows aliasing and double-change errors, as the requirements predict.

A narrow-counter instance is driven past its positive limit. A counter that saturated or sign-extended wrongly would differ from the modular expectation.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic {
        ST_SEED  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_e;

    // difference of phase indices modulo 4
    typedef enum logic [1:0] {
        MV_HOLD   = 2'd0,
        MV_UP     = 2'd1,
        MV_DOUBLE = 2'd2,
        MV_DOWN   = 2'd3
    } move_e;

    // maps {B,A} onto its position in the forward cycle 00,01,11,10
    function automatic logic [1:0] phase_of(input logic [1:0] ba);
        return {ba[1], ba[1] ^ ba[0]};
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_ff @(posedge clk) begin
            stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/qdec_strobe.sv
module qdec_strobe #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             sample_en
);

    localparam int PER_W = (1 << SEL_W) - 1;

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] limit;
    logic [SEL_W-1:0] act_q;

    always_comb limit = PER_W'((1 << act_q) - 1);

    assign sample_en = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (sample_en) begin
            cnt_q <= '0;
            act_q <= div_sel;
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

    AST_SEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(act_q)); // R8

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && div_sel == '0) |=> sample_en); // R7

endmodule

// File: rtl/qdec_step.sv
module qdec_step
    import qdec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic [1:0]              ab_sync,
    input  logic                    err_clr,
    output logic signed [CNT_W-1:0] pos,
    output logic                    count_err
);

    trk_state_e state_q, state_d;
    logic [1:0] prev_q;
    move_e      move;
    logic       judge;

    always_comb move = move_e'(phase_of(ab_sync) - phase_of(prev_q));

    assign judge = sample_en && (state_q == ST_TRACK);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEED:  state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEED;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= '0;
            pos       <= '0;
            count_err <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SEED: prev_q <= ab_sync;
                ST_TRACK: begin
                    if (sample_en) begin
                        prev_q <= ab_sync;
                        unique case (move)
                            MV_UP:   pos <= pos + CNT_W'(1);
                            MV_DOWN: pos <= pos - CNT_W'(1);
                            default: ;
                        endcase
                    end
                end
            endcase
            if (judge && move == MV_DOUBLE) count_err <= 1'b1;
            else if (err_clr)               count_err <= 1'b0;
        end
    end

    AST_SEED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEED) |=> $stable(pos)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !judge |=> $stable(pos)); // R7

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        judge |=> (pos == $past(pos) || pos == $past(pos) + CNT_W'(1)
                   || pos == $past(pos) - CNT_W'(1))); // R2

    AST_DOUBLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (judge && move == MV_DOUBLE) |=> (count_err && $stable(pos))); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (count_err && !err_clr) |=> count_err); // R6

endmodule

// File: rtl/qdec_top.sv
module qdec_top #(
    parameter int CNT_W  = 32,
    parameter int SEL_W  = 2,
    parameter int SYNC_N = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enc_a,
    input  logic                    enc_b,
    input  logic [SEL_W-1:0]        div_sel,
    input  logic                    err_clr,
    output logic signed [CNT_W-1:0] position,
    output logic                    count_err
);

    logic [1:0] ab_sync;
    logic       sample_en;

    qdec_sync #(.W(2), .STAGES(SYNC_N)) i_sync (
        .clk (clk),
        .d   ({enc_b, enc_a}),
        .q   (ab_sync)
    );

    qdec_strobe #(.SEL_W(SEL_W)) i_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_sel   (div_sel),
        .sample_en (sample_en)
    );

    qdec_step #(.CNT_W(CNT_W)) i_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .ab_sync   (ab_sync),
        .err_clr   (err_clr),
        .pos       (position),
        .count_err (count_err)
    );

endmodule

// File: tb/test_qdec_top.sv
module test_qdec_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 1'b0, enc_b = 1'b0, err_clr = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic signed [31:0] position;
    logic count_err;
    logic signed [3:0] pos_nar;
    logic err_nar;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdec_top i_qdec_top (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .div_sel(div_sel), .err_clr(err_clr),
        .position(position), .count_err(count_err));

    qdec_top #(.CNT_W(4)) i_qdec_top_nar (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .div_sel(div_sel), .err_clr(err_clr),
        .position(pos_nar), .count_err(err_nar));

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit cmp_on = 0;
    bit done = 0;

    // behavioural reference
    int seq[4] = '{0, 1, 3, 2};
    int s1 = 0, s2 = 0, prev = 0, dcnt = 0, act = 0;
    bit seeded = 0;
    logic signed [31:0] m_pos = 0;
    logic signed [3:0]  m_nar = 0;
    bit m_err = 0;

    function automatic int gidx(int v);
        for (int i = 0; i < 4; i++) if (seq[i] == v) return i;
        return 0;
    endfunction

    task automatic chk(bit ok, string req, string what, longint actv, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, actv, expv, $time);
        end
    endtask

    always @(posedge clk) begin
        int ab_now, d;
        bit stb, dbl, was;
        ab_now = {30'd0, enc_b, enc_a};
        if (!rst_n) begin
            m_pos = 0; m_nar = 0; m_err = 0; seeded = 0; dcnt = 0; act = 0;
        end else begin
            stb = (dcnt == (1 << act) - 1);
            was = seeded;
            dbl = 0;
            if (!was) begin
                prev = s2; seeded = 1;
            end else if (stb) begin
                d = (gidx(s2) - gidx(prev)) & 3;
                if (d == 1) begin m_pos = m_pos + 1; m_nar = m_nar + 1; end
                if (d == 3) begin m_pos = m_pos - 1; m_nar = m_nar - 1; end
                if (d == 2) dbl = 1;
                prev = s2;
            end
            if (dbl) m_err = 1;
            else if (err_clr) m_err = 0;
            if (stb) begin dcnt = 0; act = div_sel; end
            else dcnt++;
        end
        s2 = s1;
        s1 = ab_now;
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(position === m_pos, cur_req, "model position", position, m_pos);
            chk(count_err === m_err, cur_req, "model count_err", count_err, m_err);
            chk(pos_nar === m_nar, cur_req, "model narrow position", pos_nar, m_nar);
        end
    end

    task automatic step(bit fwd, int hold);
        int nx;
        nx = seq[(gidx({30'd0, enc_b, enc_a}) + (fwd ? 1 : 3)) % 4];
        @(negedge clk);
        {enc_b, enc_a} = nx[1:0];
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic signed [31:0] p0;
        {enc_b, enc_a} = 2'b11;
        idle(3);
        chk(position === 0, "R1", "position in reset", position, 0);
        chk(count_err === 1'b0, "R1", "count_err in reset", count_err, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        cur_req = "R10";
        idle(6);
        chk(position === 0, "R10", "no count at release", position, 0);

        cur_req = "R2";
        for (int i = 0; i < 8; i++) step(1, 3);
        idle(4);
        chk(position === 8, "R2", "forward steps", position, 8);

        cur_req = "R3";
        for (int i = 0; i < 12; i++) step(0, 3);
        idle(4);
        chk(position === -4, "R3", "reverse steps", position, -4);

        cur_req = "R4";
        idle(20);
        chk(position === -4, "R4", "hold position", position, -4);
        chk(count_err === 1'b0, "R4", "hold flag", count_err, 0);

        cur_req = "R11";
        p0 = position;
        step(1, 1);
        @(posedge clk); @(posedge clk); #1;
        chk(position === p0, "R11", "not yet after edge k+1", position, p0);
        @(posedge clk); #1;
        chk(position === p0 + 1, "R11", "after edge k+2", position, p0 + 1);
        idle(3);

        cur_req = "R5";
        p0 = position;
        @(negedge clk); {enc_b, enc_a} = ~{enc_b, enc_a};
        idle(5);
        chk(position === p0, "R5", "double holds count", position, p0);
        chk(count_err === 1'b1, "R5", "double sets flag", count_err, 1);

        cur_req = "R6";
        idle(10);
        chk(count_err === 1'b1, "R6", "flag sticky", count_err, 1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        idle(2);
        chk(count_err === 1'b0, "R6", "flag cleared", count_err, 0);
        @(negedge clk); {enc_b, enc_a} = ~{enc_b, enc_a};
        @(negedge clk);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        idle(2);
        chk(count_err === 1'b1, "R6", "set wins over clear", count_err, 1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        idle(2);

        cur_req = "R7";
        div_sel = 2'd3;
        idle(10);
        p0 = position;
        for (int i = 0; i < 6; i++) step(1, 10);
        idle(20);
        chk(position === p0 + 6, "R7", "slow sampling forward", position, p0 + 6);
        div_sel = 2'd1;
        for (int i = 0; i < 5; i++) step(0, 3);
        idle(6);
        div_sel = 2'd2;
        for (int i = 0; i < 9; i++) step(1, 1);
        idle(12);

        cur_req = "R8";
        div_sel = 2'd3;
        idle(11);
        div_sel = 2'd0;
        for (int i = 0; i < 4; i++) step(1, 2);
        div_sel = 2'd2;
        idle(2);
        div_sel = 2'd1;
        for (int i = 0; i < 4; i++) step(0, 5);
        idle(10);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;

        cur_req = "R9";
        div_sel = 2'd0;
        idle(10);
        for (int i = 0; i < 21; i++) step(1, 2);
        idle(4);
        chk(pos_nar === m_nar, "R9", "narrow counter wrapped", pos_nar, m_nar);
        chk(position === m_pos, "R9", "wide counter", position, m_pos);
        idle(3);
        finish_run();
    end

endmodule